// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

This block is a memory-mapped watchdog timer with two clock domains. Software reaches it through a plain valid/write/address/data port clocked by the peripheral clock `pclk`. The count itself runs on a separate oscillator clock `osc_clk`. Software loads a 12-bit period value N, sets the enable bit, and then refreshes the watchdog at intervals by writing the clear command. If one full period passes without a refresh, an interrupt is raised. If a second full period then passes without a refresh, a sticky reset request is raised. Software can also raise the reset request at once through a forced-error command. This path is used to reboot the system on purpose.

One period is `(N + 1) << PRESC_LOG2` oscillator cycles, where `PRESC_LOG2` is a prescaler exponent with a default of 20. The lapsed-time counter is `12 + PRESC_LOG2` bits wide. Its top 12 bits are compared with N. The register state lives in the `pclk` domain and is carried to the oscillator domain as one whole word by a toggle handshake. Writes to the lapsed-time register and to the force register travel inside that word as toggle bits. The refresh command uses a lighter, separate single-bit toggle synchroniser. A copy of the counter is carried back to `pclk` by the same kind of handshake so that software can read it.

The oscillator-domain controller has three states:
- `ARMED_FIRST`: counting toward the first overflow.
- `ARMED_SECOND`: one overflow has occurred and the interrupt is pending.
- `FIRED`: the reset request is asserted.

It has these transitions:
- `ARMED_FIRST -> ARMED_SECOND` on an overflow with no refresh in the same cycle.
- `ARMED_SECOND -> ARMED_FIRST` on a refresh.
- `ARMED_SECOND -> FIRED` on a second overflow.
- `ARMED_FIRST`/`ARMED_SECOND -> FIRED` on an accepted forced error.
- `FIRED` is left only by the asynchronous reset.

Register offsets on `bus_addr` (the slot is `bus_addr[4:2]`):

| Offset | Register |
|--------|----------|
| 0x00 | control: bit 0 enables counting |
| 0x04 | period: N in bits 31:20 |
| 0x08 | lapsed time |
| 0x0C | refresh/interrupt |
| 0x10 | error-action select |
| 0x14 | error force |

Top module: `wdog_dualclk`

## Requirements
- R1: Writing the period register (offset 0x04) keeps only `bus_wdata[31:20]` as N. A later read returns N in bits 31:20 and zero in bits 19:0.
- R2: Bit 0 of the control register (0x00) enables counting and reads back as written. While it is 0 the lapsed-time counter holds its value, and no interrupt or reset request arises.
- R3: After counting is enabled from zero, `irq` goes high once `(N+1) << PRESC_LOG2` oscillator cycles have been counted. It stays high until a refresh is written or the reset request fires. Bit 0 of a read at 0x0C reports `irq`.
- R4: `wdt_reset` goes high only when a second full period elapses after the first overflow, with no refresh in between.
- R5: Writing 1 in bit 0 at 0x0C (refresh) zeroes the counter and drops `irq`. Refreshing more often than one period keeps both `irq` and `wdt_reset` low.
- R6: Any write to the lapsed-time register (0x08) restarts the counter from zero. The written value is not used.
- R7: If the error-action select register (0x10) bit 0 is 0, writing 1 in bit 0 of the force register (0x14) raises `wdt_reset` within the crossing latency. If select bit 0 is 1, the force write leaves `wdt_reset` low.
- R8: Once high, `wdt_reset` stays high through refresh writes and further time, until `rst_n` is driven low.
- R9: A read of 0x08 returns a synchronised copy of the counter shifted left by `20 - PRESC_LOG2`. The period-comparing bits therefore sit in bits 31:20, and the bits below the prescaler are zero.
- R10: After `rst_n`, every register reads zero and both `irq` and `wdt_reset` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Register-port clock |
| osc_clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Overflow interrupt (oscillator domain) |
| wdt_reset | output | 1 | Sticky reset request (oscillator domain) |

## Verification
The counting function is tried with four patterns:
- Counting untouched, which separates the first-overflow time from the second and shows that `irq` comes before `wdt_reset`.
- Refreshes spaced well inside one period, which shows that refresh really restarts the count and that no overflow slips through.
- One refresh after the interrupt, which shows that the second overflow must be consecutive.
- Counting enabled and then disabled, which tells holding apart from slow counting.

The period register is driven with a table of write values, including ones with only low bits set, to separate kept bits from discarded ones. The forced-error path is tried with both select values, and the sticky reset request is tried against refreshes and against `rst_n`.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int PERIOD_W  = 12;
    localparam int PERIOD_LSB = 20;

    // register slot = bus_addr[4:2]
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_PERIOD = 3'd1;
    localparam logic [2:0] IDX_LAPSED = 3'd2;
    localparam logic [2:0] IDX_CLEAR  = 3'd3;
    localparam logic [2:0] IDX_PESEL  = 3'd4;
    localparam logic [2:0] IDX_FORCE  = 3'd5;

    typedef enum logic [1:0] {
        ARMED_FIRST  = 2'd0,
        ARMED_SECOND = 2'd1,
        FIRED        = 2'd2
    } wd_state_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic                pe_sel;
        logic                force_tgl;
        logic                lapse_tgl;
        logic                enable;
        logic [PERIOD_W-1:0] period;
    } cfg_word_t;
endpackage

// File: rtl/wdog_word_xfer.sv
`timescale 1ns/1ps
// Carries a whole word from src_clk to dst_clk with a toggle/ack handshake.
// The source resends its current word each time the previous one is acknowledged.
module wdog_word_xfer
    import wdog_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_word,
    output logic [W-1:0] dst_word
);
    xfer_state_e state_q, state_d;
    logic         src_tgl;
    logic [W-1:0] src_hold;
    logic         ack_meta, ack_sync;
    logic         req_meta, req_sync, dst_seen;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: state_d = XF_BUSY;
            XF_BUSY: if (ack_sync == src_tgl) state_d = XF_IDLE;
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= XF_IDLE;
            src_tgl  <= 1'b0;
            src_hold <= '0;
            ack_meta <= 1'b0;
            ack_sync <= 1'b0;
        end else begin
            state_q  <= state_d;
            ack_meta <= dst_seen;
            ack_sync <= ack_meta;
            if (state_q == XF_IDLE) begin
                src_hold <= src_word;
                src_tgl  <= ~src_tgl;
            end
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_meta <= 1'b0;
            req_sync <= 1'b0;
            dst_seen <= 1'b0;
            dst_word <= '0;
        end else begin
            req_meta <= src_tgl;
            req_sync <= req_meta;
            if (req_sync != dst_seen) begin
                dst_seen <= req_sync;
                dst_word <= src_hold;
            end
        end
    end
endmodule

// File: rtl/wdog_pulse_sync.sv
`timescale 1ns/1ps
// Single-cycle pulse from src_clk turned into a single-cycle pulse in dst_clk.
module wdog_pulse_sync (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic src_tgl, meta, sync, prev;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            sync <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= src_tgl;
            sync <= meta;
            prev <= sync;
        end
    end

    assign dst_pulse = sync ^ prev;
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
// Oscillator-domain counter and overflow/reset state machine.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRESC_LOG2 = 20,
    localparam int CW = PERIOD_W + PRESC_LOG2
) (
    input  logic          osc_clk,
    input  logic          rst_n,
    input  cfg_word_t     cfg,
    input  logic          clr_pulse,
    output logic [CW-1:0] count,
    output logic          irq,
    output logic          wdt_reset
);
    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          lapse_seen, force_seen;
    logic          lapse_ev, force_hit, overflow;
    logic [CW-1:0] terminal;

    assign terminal  = {cfg.period, {PRESC_LOG2{1'b1}}};
    assign lapse_ev  = cfg.lapse_tgl ^ lapse_seen;
    assign force_hit = (cfg.force_tgl ^ force_seen) && !cfg.pe_sel;
    assign overflow  = cfg.enable && (state_q != FIRED) && (cnt_q == terminal);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARMED_FIRST: begin
                if (force_hit)                  state_d = FIRED;
                else if (overflow && !clr_pulse) state_d = ARMED_SECOND;
            end
            ARMED_SECOND: begin
                if (force_hit)      state_d = FIRED;
                else if (clr_pulse) state_d = ARMED_FIRST;
                else if (overflow)  state_d = FIRED;
            end
            FIRED:   state_d = FIRED;
            default: state_d = FIRED;
        endcase
    end

    // state register, counter and event edge trackers
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ARMED_FIRST;
            cnt_q      <= '0;
            lapse_seen <= 1'b0;
            force_seen <= 1'b0;
        end else begin
            state_q    <= state_d;
            lapse_seen <= cfg.lapse_tgl;
            force_seen <= cfg.force_tgl;
            if (clr_pulse || lapse_ev)
                cnt_q <= '0;
            else if (cfg.enable && state_q != FIRED)
                cnt_q <= overflow ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        irq       = (state_q == ARMED_SECOND);
        wdt_reset = (state_q == FIRED);
        count     = cnt_q;
    end

    assert_count_hold_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!cfg.enable && !clr_pulse && !lapse_ev) |=> $stable(cnt_q));

    assert_irq_hold_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (irq && !clr_pulse && !force_hit && !overflow) |=> irq);

    assert_reset_cause_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(wdt_reset) |-> ($past(irq) || $past(force_hit)));

    assert_refresh_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (clr_pulse && !force_hit && !wdt_reset) |=> (cnt_q == '0 && !irq));

    assert_sticky_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        wdt_reset |=> wdt_reset);
endmodule

// File: rtl/wdog_dualclk.sv
`timescale 1ns/1ps
// Top: register file in pclk, crossings, oscillator-domain core.
// PRESC_LOG2 must lie in 1..20.
module wdog_dualclk
    import wdog_pkg::*;
#(
    parameter int PRESC_LOG2 = 20
) (
    input  logic        pclk,
    input  logic        osc_clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wdt_reset
);
    localparam int CW    = PERIOD_W + PRESC_LOG2;
    localparam int SHIFT = PERIOD_LSB - PRESC_LOG2;
    localparam int CFG_W = $bits(cfg_word_t);

    logic [2:0]          idx;
    logic                en_r, pe_sel_r, force_r;
    logic                lapse_tgl_r, force_tgl_r, clr_pulse_r;
    logic [PERIOD_W-1:0] period_r;
    logic                irq_meta, irq_sync;
    logic [31:0]         rd_mux, snap_aligned;
    cfg_word_t           cfg_src, cfg_dst;
    logic [CFG_W-1:0]    cfg_dst_bits;
    logic [CW-1:0]       count_osc, count_snap;
    logic                clr_osc;
    logic                unused_bus;

    assign idx        = bus_addr[4:2];
    assign unused_bus = ^{bus_addr[1:0], bus_wdata[19:1]};

    // register writes (pclk)
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            en_r        <= 1'b0;
            period_r    <= '0;
            pe_sel_r    <= 1'b0;
            force_r     <= 1'b0;
            lapse_tgl_r <= 1'b0;
            force_tgl_r <= 1'b0;
            clr_pulse_r <= 1'b0;
        end else begin
            clr_pulse_r <= 1'b0;
            if (bus_valid && bus_write) begin
                case (idx)
                    IDX_CTRL:   en_r        <= bus_wdata[0];
                    IDX_PERIOD: period_r    <= bus_wdata[31:PERIOD_LSB];
                    IDX_LAPSED: lapse_tgl_r <= ~lapse_tgl_r;
                    IDX_CLEAR:  clr_pulse_r <= bus_wdata[0];
                    IDX_PESEL:  pe_sel_r    <= bus_wdata[0];
                    IDX_FORCE: begin
                        force_r <= bus_wdata[0];
                        if (bus_wdata[0]) force_tgl_r <= ~force_tgl_r;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cfg_src = '{pe_sel: pe_sel_r, force_tgl: force_tgl_r,
                       lapse_tgl: lapse_tgl_r, enable: en_r, period: period_r};

    wdog_word_xfer #(.W(CFG_W)) u_cfg_xfer (
        .src_clk  (pclk),
        .dst_clk  (osc_clk),
        .rst_n    (rst_n),
        .src_word (cfg_src),
        .dst_word (cfg_dst_bits)
    );
    assign cfg_dst = cfg_word_t'(cfg_dst_bits);

    wdog_pulse_sync u_clr_sync (
        .src_clk   (pclk),
        .dst_clk   (osc_clk),
        .rst_n     (rst_n),
        .src_pulse (clr_pulse_r),
        .dst_pulse (clr_osc)
    );

    wdog_core #(.PRESC_LOG2(PRESC_LOG2)) u_core (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .cfg       (cfg_dst),
        .clr_pulse (clr_osc),
        .count     (count_osc),
        .irq       (irq),
        .wdt_reset (wdt_reset)
    );

    wdog_word_xfer #(.W(CW)) u_snap_xfer (
        .src_clk  (osc_clk),
        .dst_clk  (pclk),
        .rst_n    (rst_n),
        .src_word (count_osc),
        .dst_word (count_snap)
    );

    // interrupt status into pclk
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            irq_meta <= 1'b0;
            irq_sync <= 1'b0;
        end else begin
            irq_meta <= irq;
            irq_sync <= irq_meta;
        end
    end

    assign snap_aligned = 32'(count_snap) << SHIFT;

    always_comb begin
        case (idx)
            IDX_CTRL:   rd_mux = {31'd0, en_r};
            IDX_PERIOD: rd_mux = {period_r, {PERIOD_LSB{1'b0}}};
            IDX_LAPSED: rd_mux = snap_aligned;
            IDX_CLEAR:  rd_mux = {31'd0, irq_sync};
            IDX_PESEL:  rd_mux = {31'd0, pe_sel_r};
            IDX_FORCE:  rd_mux = {31'd0, force_r};
            default:    rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end

    assert_period_low_zero_R1: assert property (@(posedge pclk) disable iff (!rst_n)
        (bus_valid && !bus_write && idx == IDX_PERIOD) |=> (bus_rdata[PERIOD_LSB-1:0] == '0));
endmodule

// File: tb/wdog_dualclk_tb.sv
`timescale 1ns/1ps
module wdog_dualclk_tb_top;
    localparam int P = 4;   // period = 16*(N+1) osc cycles

    logic        pclk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_reset;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 pclk = ~pclk;       // 125 MHz
    always #7 osc_clk = ~osc_clk;

    wdog_dualclk #(.PRESC_LOG2(P)) dut_i (
        .pclk(pclk), .osc_clk(osc_clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdt_reset(wdt_reset)
    );

    // period write value, expected readback
    localparam logic [31:0] PER_VEC [5][2] = '{
        '{32'hFFFF_FFFF, 32'hFFF0_0000},
        '{32'h1234_5678, 32'h1230_0000},
        '{32'h000F_FFFF, 32'h0000_0000},
        '{32'h0010_0000, 32'h0010_0000},
        '{32'hA5AF_0001, 32'hA5A0_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge pclk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge pclk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge pclk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_ns(input int t);
        #(t);
        @(negedge osc_clk);
    endtask

    task automatic do_reset();
        @(negedge pclk);
        rst_n = 1'b0;
        #50;
        @(negedge pclk);
        rst_n = 1'b1;
        #40;
    endtask

    initial begin
        #200us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors + 0);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, b;
        do_reset();

        // R10 reset state
        bus_rd(5'h00, rd); chk("R10 ctrl after reset", rd, 0);
        bus_rd(5'h04, rd); chk("R10 period after reset", rd, 0);
        bus_rd(5'h08, rd); chk("R10 lapsed after reset", rd, 0);
        bus_rd(5'h0C, rd); chk("R10 irq status after reset", rd, 0);
        chk("R10 irq pin after reset", {31'd0, irq}, 0);
        chk("R10 reset pin after reset", {31'd0, wdt_reset}, 0);

        // R1 table of period writes
        for (int i = 0; i < 5; i++) begin
            bus_wr(5'h04, PER_VEC[i][0]);
            bus_rd(5'h04, rd);
            chk("R1 period field readback", rd, PER_VEC[i][1]);
        end

        // R3/R4 free-running: N=3, period 64 osc cycles = 896 ns
        do_reset();
        bus_wr(5'h04, 32'h0030_0000);
        bus_wr(5'h00, 32'h1);
        bus_rd(5'h00, rd); chk("R2 ctrl readback", rd, 32'h1);
        wait_ns(780);
        chk("R3 no irq before one period", {31'd0, irq}, 0);
        wait_ns(480);
        chk("R3 irq after one period", {31'd0, irq}, 1);
        bus_rd(5'h0C, rd); chk("R3 irq status read", rd, 1);
        wait_ns(380);
        chk("R4 no reset before second period", {31'd0, wdt_reset}, 0);
        chk("R3 irq still pending", {31'd0, irq}, 1);
        wait_ns(600);
        chk("R4 reset after second period", {31'd0, wdt_reset}, 1);

        // R8 sticky
        bus_wr(5'h0C, 32'h1);
        wait_ns(1000);
        chk("R8 reset survives refresh and time", {31'd0, wdt_reset}, 1);
        do_reset();
        chk("R8 reset cleared by rst_n", {31'd0, wdt_reset}, 0);

        // R5 periodic refresh
        bus_wr(5'h04, 32'h0030_0000);
        bus_wr(5'h00, 32'h1);
        for (int k = 0; k < 6; k++) begin
            wait_ns(500);
            bus_wr(5'h0C, 32'h1);
            chk("R5 no irq while refreshed", {31'd0, irq}, 0);
        end
        chk("R5 no reset while refreshed", {31'd0, wdt_reset}, 0);
        wait_ns(1300);
        chk("R3 irq once refreshes stop", {31'd0, irq}, 1);
        bus_wr(5'h0C, 32'h1);
        wait_ns(200);
        chk("R5 refresh drops irq", {31'd0, irq}, 0);
        wait_ns(1100);
        chk("R4 overflow after refresh is first again", {31'd0, irq}, 1);
        chk("R4 no reset since refresh broke the pair", {31'd0, wdt_reset}, 0);

        // R2 disable holds
        do_reset();
        bus_wr(5'h04, 32'h0030_0000);
        bus_wr(5'h00, 32'h1);
        wait_ns(400);
        bus_wr(5'h00, 32'h0);
        wait_ns(200);
        bus_rd(5'h08, a);
        wait_ns(2000);
        bus_rd(5'h08, b);
        chk("R2 counter holds while disabled", b, a);
        chk("R2 counter had advanced", {31'd0, (a != 0)}, 1);
        chk("R9 low bits of lapsed read zero", {16'd0, a[15:0]}, 0);
        chk("R9 snapshot below one period", {31'd0, (a < 32'h0040_0000)}, 1);
        chk("R2 no irq while disabled", {31'd0, irq}, 0);

        // R6 lapsed write restarts
        do_reset();
        bus_wr(5'h04, 32'hFFF0_0000);
        bus_wr(5'h00, 32'h1);
        wait_ns(1500);
        bus_rd(5'h08, a);
        bus_wr(5'h08, 32'hDEAD_BEEF);
        wait_ns(100);
        bus_rd(5'h08, b);
        chk("R6 lapsed write restarts count", {31'd0, (b < a)}, 1);
        chk("R9 tick bits aligned at 31:20", {31'd0, (a[31:20] != 0)}, 1);

        // R7 forced error, select 0
        do_reset();
        bus_wr(5'h14, 32'h1);
        wait_ns(200);
        chk("R7 forced error raises reset", {31'd0, wdt_reset}, 1);

        // R7 forced error, select 1
        do_reset();
        bus_wr(5'h10, 32'h1);
        wait_ns(200);
        bus_wr(5'h14, 32'h1);
        wait_ns(400);
        chk("R7 force ignored with select 1", {31'd0, wdt_reset}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule